// File: doc/BRIEF.md
# Memory-Mapped Countdown Timer with Maskable Expiry

This block is a word-addressed register slave around a down-counter. Software first writes a start value into the load register. It then sets the enable and mode bits in the control register. The counter steps down once per prescaled tick. When a tick finds it at zero, the block records an expiry:

- **Periodic mode** reloads the counter from the load register.
- **Free-running mode** wraps the counter to all ones.

An expiry sets a pollable flag, which is visible both in the status register and in the end-of-interrupt register. A read of the end-of-interrupt register clears the flag.

The control register also holds an active-high mask bit. While the mask is set, expiries are not recorded: no flag is set and no interrupt is raised. The interrupt output is a level. It is high while the flag is set and the mask is clear.

Register word offsets:

| Offset | Register | Access |
|---|---|---|
| 0 | load | read/write |
| 4 | status | read-only |
| 8 | control | read/write |
| 12 | end-of-interrupt | read clears the flag |
| 16 | current count | read-only |

Read data is combinational from the address.

Top module: `down_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is low.
- R2: The load register (offset 0) reads back its last written value. The control register (offset 8) reads back bit 0 = enable, bit 1 = periodic mode and bit 2 = mask, with all other bits reading 0.
- R3: The enable bit is seen set one clock after the write that sets it. On the following clock the counter is loaded from the load register. After that, while enabled, the counter decreases by one every PRESCALE_DIV clocks. It is readable at offset 16.
- R4: In periodic mode (bit 1 = 1), a tick that finds the counter at 0 is an expiry, and the counter is reloaded from the load register.
- R5: In free-running mode (bit 1 = 0), an expiry wraps the counter to 0xFFFFFFFF.
- R6: An expiry with the mask bit at 0 sets bit 0 of status (offset 4) and bit 0 of end-of-interrupt (offset 12) together.
- R7: A read of offset 12 returns the flag and clears both flag bits on the next clock.
- R8: While the mask bit is 1, expiries never set the flag, and `irq` stays low.
- R9: `irq` is high exactly when the flag is set and the mask bit is 0. It is a level that holds until the end-of-interrupt read.
- R10: With the enable bit at 0, the counter holds its value.
- R11: If an expiry and an end-of-interrupt read fall in the same clock, the flag ends set.
- R12: Writes to offsets 4, 12 and 16, and writes to addresses whose two low bits are not 0, change nothing. Unaligned reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for one clock |
| rdEn | input | 1 | Read strobe for one clock (side effect only at offset 12) |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data for `addr` |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume these properties of the block's inputs:

- `rdEn` and `wrEn` are single-clock strobes on an address that is held stable while the strobe is high.
- The counter cannot leave its reload or wrap value by any path other than a tick, a reload or an enable rise.

The stimulus drives every strobe for exactly one clock and returns the address to the count register when idle. It uses a prescale of 2 so that the tick spacing is exercised. The stimulus times the same-cycle collision of an expiry with an end-of-interrupt read from the bench's own model, so that the collision is hit exactly.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int unsigned CTRL_EN_BIT   = 0;
  localparam int unsigned CTRL_PER_BIT  = 1;
  localparam int unsigned CTRL_MASK_BIT = 2;

  localparam int unsigned IDX_LOAD  = 0;
  localparam int unsigned IDX_STAT  = 1;
  localparam int unsigned IDX_CTRL  = 2;
  localparam int unsigned IDX_EOI   = 3;
  localparam int unsigned IDX_COUNT = 4;

  // Strobes from the register control to the counting datapath.
  typedef struct packed {
    logic loadNow;
    logic run;
    logic periodic;
    logic mask;
    logic eoiRead;
  } tmrStrobe_t;

endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] count,
  input  logic              flag,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] loadVal,
  output tmrStrobe_t        strobe
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             enQ, perQ, maskQ, enPrevQ;
  logic [DATA_W-1:0] loadQ;

  assign wordIdx = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loadQ   <= '0;
      enQ     <= 1'b0;
      perQ    <= 1'b0;
      maskQ   <= 1'b0;
      enPrevQ <= 1'b0;
    end else begin
      enPrevQ <= enQ;
      if (wrEn && aligned && wordIdx == IDX_W'(IDX_LOAD)) loadQ <= wrData;
      if (wrEn && aligned && wordIdx == IDX_W'(IDX_CTRL)) begin
        enQ   <= wrData[CTRL_EN_BIT];
        perQ  <= wrData[CTRL_PER_BIT];
        maskQ <= wrData[CTRL_MASK_BIT];
      end
    end
  end

  always_comb begin
    strobe.loadNow  = enQ && !enPrevQ;
    strobe.run      = enQ && enPrevQ;
    strobe.periodic = perQ;
    strobe.mask     = maskQ;
    strobe.eoiRead  = rdEn && aligned && (wordIdx == IDX_W'(IDX_EOI));
  end

  assign loadVal = loadQ;

  always_comb begin
    rdData = '0;
    if (aligned) begin
      if (wordIdx == IDX_W'(IDX_LOAD))       rdData = loadQ;
      else if (wordIdx == IDX_W'(IDX_STAT))  rdData[0] = flag;
      else if (wordIdx == IDX_W'(IDX_CTRL)) begin
        rdData[CTRL_EN_BIT]   = enQ;
        rdData[CTRL_PER_BIT]  = perQ;
        rdData[CTRL_MASK_BIT] = maskQ;
      end
      else if (wordIdx == IDX_W'(IDX_EOI))   rdData[0] = flag;
      else if (wordIdx == IDX_W'(IDX_COUNT)) rdData = count;
    end
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned PRESCALE_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  logic [DATA_W-1:0] loadVal,
  output logic [DATA_W-1:0] count,
  output logic              flag,
  output logic              expiry
);

  logic tick;
  logic [DATA_W-1:0] countQ;
  logic flagQ;

  generate
    if (PRESCALE_DIV <= 1) begin : g_noPre
      assign tick = strobe.run;
    end else begin : g_pre
      localparam int unsigned PRE_W = $clog2(PRESCALE_DIV);
      logic [PRE_W-1:0] preQ;
      logic preWrap;
      assign preWrap = (preQ == PRE_W'(PRESCALE_DIV - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             preQ <= '0;
        else if (!strobe.run)  preQ <= '0;
        else if (preWrap)      preQ <= '0;
        else                   preQ <= preQ + 1'b1;
      end
      assign tick = strobe.run && preWrap;
    end
  endgenerate

  assign expiry = tick && (countQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadNow) begin
      countQ <= loadVal;
    end else if (expiry) begin
      countQ <= strobe.periodic ? loadVal : '1;
    end else if (tick) begin
      countQ <= countQ - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        flagQ <= 1'b0;
    else if (expiry && !strobe.mask)  flagQ <= 1'b1;
    else if (strobe.eoiRead)          flagQ <= 1'b0;
  end

  assign count = countQ;
  assign flag  = flagQ;

endmodule

// File: rtl/down_timer.sv
module down_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W       = 32,
  parameter int unsigned ADDR_W       = 5,
  parameter int unsigned PRESCALE_DIV = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  tmrStrobe_t        strobe;
  logic [DATA_W-1:0] loadVal;
  logic [DATA_W-1:0] count;
  logic              flag;
  logic              expiry;

  timer_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .count(count), .flag(flag), .rdData(rdData),
    .loadVal(loadVal), .strobe(strobe)
  );

  timer_datapath #(.DATA_W(DATA_W), .PRESCALE_DIV(PRESCALE_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
    .count(count), .flag(flag), .expiry(expiry)
  );

  assign irq = flag && !strobe.mask;

endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input tmrStrobe_t        strobe,
  input logic [DATA_W-1:0] loadVal,
  input logic [DATA_W-1:0] count,
  input logic              flag,
  input logic              expiry
);

  p_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && strobe.periodic) |=> (count == $past(loadVal)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && !strobe.periodic) |=> (count == {DATA_W{1'b1}}));

  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && !strobe.mask) |=> flag);

  p_eoi_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiRead && !expiry) |=> !flag);

  p_mask_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mask && !flag) |=> !flag);

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.loadNow) |=> $stable(count));

  p_collide_r11: assert property (@(posedge clk) disable iff (!rstN)
    (expiry && strobe.eoiRead && !strobe.mask) |=> flag);

endmodule

bind down_timer timer_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .loadVal(loadVal),
  .count(count), .flag(flag), .expiry(expiry)
);

// File: tb/down_timer_test.sv
`timescale 1ns/1ps
module down_timer_test;

  localparam int DIV = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = 5'd16;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  down_timer #(.DATA_W(32), .ADDR_W(5), .PRESCALE_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // Behavioural reference model
  logic [31:0] mLoad = '0, mCnt = '0;
  logic mEn = 0, mPer = 0, mMask = 0, mEnPrev = 0, mFlag = 0;
  int mPre = 0;

  always @(posedge clk) begin : model
    logic lNow, run, tk, ex, eoi;
    if (!rstN) begin
      mLoad = '0; mCnt = '0; mEn = 0; mPer = 0; mMask = 0;
      mEnPrev = 0; mFlag = 0; mPre = 0;
    end else begin
      lNow = mEn && !mEnPrev;
      run  = mEn && mEnPrev;
      tk   = run && (mPre == DIV - 1);
      ex   = tk && (mCnt == 0);
      eoi  = rdEn && (addr == 5'd12);
      if (lNow) mCnt = mLoad;
      else if (ex) mCnt = mPer ? mLoad : 32'hFFFF_FFFF;
      else if (tk) mCnt = mCnt - 1;
      if (!run || tk) mPre = 0; else mPre = mPre + 1;
      if (ex && !mMask) mFlag = 1;
      else if (eoi) mFlag = 0;
      mEnPrev = mEn;
      if (wrEn && addr == 5'd0) mLoad = wrData;
      if (wrEn && addr == 5'd8) begin
        mEn = wrData[0]; mPer = wrData[1]; mMask = wrData[2];
      end
    end
  end

  function automatic logic [31:0] expRd(logic [4:0] a);
    if (a[1:0] != 2'b00) return '0;
    case (a[4:2])
      3'd0: return mLoad;
      3'd1: return {31'd0, mFlag};
      3'd2: return {29'd0, mMask, mPer, mEn};
      3'd3: return {31'd0, mFlag};
      3'd4: return mCnt;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R9 irq level", {31'd0, irq}, {31'd0, mFlag && !mMask});
      case (addr)
        5'd16:   chk("R3/R4/R5/R10 count", rdData, expRd(addr));
        5'd4:    chk("R6 status", rdData, expRd(addr));
        5'd12:   chk("R7 eoi", rdData, expRd(addr));
        default: chk("R2/R12 regs", rdData, expRd(addr));
      endcase
    end
  end

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(posedge clk); #2;
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 0; addr = 5'd16;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #2;
    rdEn = 1; addr = a;
    @(negedge clk); d = rdData;
    @(posedge clk); #2;
    rdEn = 0; addr = 5'd16;
  endtask

  task automatic waitIrq(input int lim, output bit seen);
    seen = 0;
    for (int i = 0; i < lim; i++) begin
      @(negedge clk);
      if (irq) begin seen = 1; break; end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    bit seen;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    // R1 reset state
    foreach (v[i]) ; // no-op
    for (int a = 0; a < 5; a++) begin
      rd(5'(a * 4), v);
      chk("R1 reset reg", v, 32'd0);
    end
    chk("R1 reset irq", {31'd0, irq}, 32'd0);

    // R2 readback
    wr(5'd0, 32'd40);
    rd(5'd0, v); chk("R2 load readback", v, 32'd40);
    wr(5'd8, 32'hFFFF_FFF3);
    rd(5'd8, v); chk("R2 ctrl readback", v, 32'd3);

    // R3 count loaded and decrementing
    rd(5'd16, v);
    chk("R3 count loaded range", {31'd0, (v <= 32'd40) && (v >= 32'd35)}, 32'd1);

    // R6 expiry sets status and eoi; R9 irq
    waitIrq(500, seen);
    chk("R9 irq after expiry", {31'd0, seen}, 32'd1);
    rd(5'd4, v); chk("R6 status set", v, 32'd1);
    rd(5'd12, v); chk("R7 eoi returns flag", v, 32'd1);
    rd(5'd4, v); chk("R7 status cleared", v, 32'd0);

    // R9 mask on flagged state hides irq, unmask restores it
    waitIrq(500, seen);
    wr(5'd8, 32'd7);
    @(negedge clk);
    chk("R9 irq masked", {31'd0, irq}, 32'd0);
    rd(5'd4, v); chk("R9 flag kept under mask", v, 32'd1);
    wr(5'd8, 32'd3);
    @(negedge clk);
    chk("R9 irq restored", {31'd0, irq}, 32'd1);
    rd(5'd12, v);

    // R8 masked expiries set nothing
    wr(5'd8, 32'd7);
    repeat (250) @(posedge clk);
    rd(5'd4, v); chk("R8 status stays clear", v, 32'd0);
    rd(5'd12, v); chk("R8 eoi stays clear", v, 32'd0);
    chk("R8 irq low", {31'd0, irq}, 32'd0);

    // R11 expiry coincides with eoi read
    wr(5'd8, 32'd3);
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #2;
      if (mEn && mEnPrev && mPre == DIV - 1 && mCnt == 0) break;
    end
    rdEn = 1; addr = 5'd12;
    @(posedge clk); #2;
    rdEn = 0; addr = 5'd16;
    rd(5'd4, v); chk("R11 expiry wins over eoi", v, 32'd1);
    rd(5'd12, v);

    // R10 freeze
    wr(5'd8, 32'd2);
    rd(5'd16, v);
    repeat (15) @(posedge clk);
    rd(5'd16, v2); chk("R10 count frozen", v2, v);

    // R5 free-running wrap
    wr(5'd0, 32'd3);
    wr(5'd8, 32'd1);
    repeat (20) @(posedge clk);
    rd(5'd16, v);
    chk("R5 wrapped high", {31'd0, v > 32'hFFFF_0000}, 32'd1);
    rd(5'd4, v); chk("R6 free-run status", v, 32'd1);

    // R12 read-only and unaligned writes ignored
    wr(5'd8, 32'd0);
    rd(5'd16, v);
    wr(5'd16, 32'd0);
    wr(5'd4, 32'd0);
    wr(5'd12, 32'd0);
    wr(5'd1, 32'd99);
    wr(5'd9, 32'd7);
    rd(5'd16, v2); chk("R12 count write ignored", v2, v);
    rd(5'd4, v2); chk("R12 status write ignored", v2, 32'd1);
    rd(5'd0, v2); chk("R12 unaligned load write ignored", v2, 32'd3);
    rd(5'd8, v2); chk("R12 unaligned ctrl write ignored", v2, 32'd0);
    rd(5'd2, v2); chk("R12 unaligned read zero", v2, 32'd0);

    repeat (5) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule